// File: doc/BRIEF.md
# 74181-Style Mixed Logic/Arithmetic ALU

An 8-bit ALU in which one per-bit network of generate and propagate terms serves both sixteen bitwise logic functions and sixteen arithmetic functions. A 4-bit select code picks the function. A mode bit picks the family: 1 gives logic and 0 gives arithmetic. The carries come from two 4-bit carry-lookahead slices, and a second lookahead level joins the two slices.

In arithmetic mode each function is a sum U + V + carry-in. The code builds U and V from the operands. U is MA ORed with MB and/or with NOT MB. V is MA ANDed with MB and/or with NOT MB. In logic mode the generate terms are forced to zero, and the propagate vector holds the logic value, so the carry-in adds one to it. In arithmetic mode a mask control clears operand bits 7 and 6 of MA before the operation. Results and carry-out are registered. They appear one clock after the inputs are sampled.

Top module: `alu181_core`

## Requirements
- R1: A synchronous active-high reset clears `result` and `carry_out` to 0. Otherwise both outputs show, one clock later, the function of the inputs sampled at a rising edge.
- R2: With `logic_mode`=1 and `carry_in`=0, `carry_out` is 0. `result` by `fn_sel` is: 0→0, 1→A&B, 2→A&~B, 3→A, 4→~A&B, 5→B, 6→A^B, 7→A|B, 8→~(A|B), 9→~(A^B), 10→~B, 11→A|~B, 12→~A, 13→~A|B, 14→~(A&B), 15→all ones.
- R3: With `logic_mode`=1 and `carry_in`=1, {`carry_out`,`result`} is the R2 value plus one, taken as a 9-bit sum.
- R4: With `logic_mode`=0, {`carry_out`,`result`} = U + V + `carry_in` as a 9-bit sum. U is A for codes 0–3, A|B for 4–7, A|~B for 8–11, and 0xFF for 12–15. V by `fn_sel[1:0]` is 0 for 0, A&B for 1, A&~B for 2, and A for 3.
- R5: Code 5 in arithmetic mode is the binary sum A + B + `carry_in`, with `carry_out` being the carry out of bit 7.
- R6: Code 10 in arithmetic mode with `carry_in`=1 gives A − B modulo 256, with `carry_out`=1 exactly when A ≥ B.
- R7: With `logic_mode`=0 and `mask_hi`=1, bits 7 and 6 of A are taken as 0 in every arithmetic function.
- R8: With `logic_mode`=1, `mask_hi` has no effect on `result` or `carry_out`.
- R9: A carry out of bit 3 reaches bit 4 and beyond in the same cycle. For example, 0x0F + 0x01 gives 0x10, and 0xFF + 0x00 with carry-in 1 gives 0x00 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| fn_sel | input | 4 | Function select code 0–15 |
| logic_mode | input | 1 | 1 = logic family, 0 = arithmetic family |
| mask_hi | input | 1 | In arithmetic mode, clears A bits 7:6 |
| carry_in | input | 1 | Carry-in, adds one to the result |
| result | output | 8 | Registered result |
| carry_out | output | 1 | Registered carry out of bit 7 |

## Verification
The bench sweeps every select code in both modes, with both carry-in values and both mask settings, over operand patterns that mix nibble values. This makes a wrong generate, propagate or lookahead term visible at `result` on the clock after the stimulus. A fault in the upper slice's carry-in shows only as a wrong bit 4–7 or carry-out when the low nibble produces or passes a carry. Directed vectors force those boundary cases, along with all-ones and zero operands. A masking fault shows only in arithmetic mode with A bits 7:6 set, and the sweep covers both states of those bits.

// File: rtl/alu181_pkg.sv
package alu181_pkg;

  // Bit positions inside the function select that enable each operand term
  localparam int SELB_V_AB  = 0;  // V gets A & B
  localparam int SELB_V_ANB = 1;  // V gets A & ~B
  localparam int SELB_U_B   = 2;  // U gets | B
  localparam int SELB_U_NB  = 3;  // U gets | ~B

  typedef enum logic [3:0] {
    SEL_PASS   = 4'd0,
    SEL_DOUBLE = 4'd3,
    SEL_ADD    = 4'd5,
    SEL_SUBM1  = 4'd10,
    SEL_MINUS1 = 4'd12,
    SEL_DEC    = 4'd15
  } alu_sel_e;

endpackage

// File: rtl/alu181_operand_mask.sv
module alu181_operand_mask #(
  parameter int W         = 8,
  parameter int MASK_BITS = 2
) (
  input  logic [W-1:0] a_in,
  input  logic         arith,
  input  logic         mask_en,
  output logic [W-1:0] a_out
);
  localparam int LOW_TOP = W - MASK_BITS;

  logic kill;
  assign kill = arith & mask_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= LOW_TOP) begin : g_masked
      assign a_out[i] = a_in[i] & ~kill;
    end else begin : g_plain
      assign a_out[i] = a_in[i];
    end
  end
endmodule

// File: rtl/alu181_gp_stage.sv
module alu181_gp_stage
  import alu181_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   sel,
  input  logic         logic_mode,
  output logic [W-1:0] gen,
  output logic [W-1:0] xp
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic u_term;
    logic v_term;
    logic half_sum;

    // U always covers V, so U & ~V is the exclusive-or of the two addends
    assign u_term   = a[i] | (sel[SELB_U_B] & b[i]) | (sel[SELB_U_NB] & ~b[i]);
    assign v_term   = (sel[SELB_V_AB] & a[i] & b[i]) | (sel[SELB_V_ANB] & a[i] & ~b[i]);
    assign half_sum = u_term & ~v_term;

    // Logic family: replace the would-be carry vector with A itself
    assign xp[i]  = logic_mode ? (half_sum ^ a[i]) : half_sum;
    assign gen[i] = logic_mode ? 1'b0 : v_term;
  end
endmodule

// File: rtl/alu181_cla_slice.sv
module alu181_cla_slice #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         c_in,
  output logic [N-1:0] c_bit,
  output logic         grp_g,
  output logic         grp_p
);
  // Every carry is a flat sum of products over gen/prop and c_in
  always_comb begin : la_calc
    logic acc;
    logic term;
    for (int k = 0; k < N; k++) begin
      term = c_in;
      for (int m = 0; m < k; m++) term = term & prop[m];
      acc = term;
      for (int j = 0; j < k; j++) begin
        term = gen[j];
        for (int m = j + 1; m < k; m++) term = term & prop[m];
        acc = acc | term;
      end
      c_bit[k] = acc;
    end

    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen[j];
      for (int m = j + 1; m < N; m++) term = term & prop[m];
      acc = acc | term;
    end
    grp_g = acc;
    grp_p = &prop;
  end
endmodule

// File: rtl/alu181_core.sv
module alu181_core #(
  parameter int WIDTH     = 8,
  parameter int SLICE_W   = 4,
  parameter int MASK_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       fn_sel,
  input  logic             logic_mode,
  input  logic             mask_hi,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int N_SLICES = WIDTH / SLICE_W;

  logic [WIDTH-1:0]    a_eff;
  logic [WIDTH-1:0]    gen;
  logic [WIDTH-1:0]    xp;
  logic [WIDTH-1:0]    carries;
  logic [N_SLICES-1:0] slice_g;
  logic [N_SLICES-1:0] slice_p;
  logic [N_SLICES-1:0] slice_cin;
  logic                all_g;
  logic                all_p;
  logic [WIDTH-1:0]    sum_d;
  logic                cout_d;

  alu181_operand_mask #(.W(WIDTH), .MASK_BITS(MASK_BITS)) u_mask (
    .a_in    (op_a),
    .arith   (~logic_mode),
    .mask_en (mask_hi),
    .a_out   (a_eff)
  );

  alu181_gp_stage #(.W(WIDTH)) u_gp (
    .a          (a_eff),
    .b          (op_b),
    .sel        (fn_sel),
    .logic_mode (logic_mode),
    .gen        (gen),
    .xp         (xp)
  );

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    alu181_cla_slice #(.N(SLICE_W)) u_cla (
      .gen   (gen[s*SLICE_W +: SLICE_W]),
      .prop  (xp[s*SLICE_W +: SLICE_W]),
      .c_in  (slice_cin[s]),
      .c_bit (carries[s*SLICE_W +: SLICE_W]),
      .grp_g (slice_g[s]),
      .grp_p (slice_p[s])
    );
  end

  // Second lookahead level: one carry-in per slice from group terms
  alu181_cla_slice #(.N(N_SLICES)) u_grp (
    .gen   (slice_g),
    .prop  (slice_p),
    .c_in  (carry_in),
    .c_bit (slice_cin),
    .grp_g (all_g),
    .grp_p (all_p)
  );

  assign sum_d  = xp ^ carries;
  assign cout_d = all_g | (all_p & carry_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= sum_d;
      carry_out <= cout_d;
    end
  end
endmodule

// File: rtl/alu181_core_chk.sv
module alu181_core_chk
  import alu181_pkg::*;
#(
  parameter int W         = 8,
  parameter int MASK_BITS = 2
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [3:0]   fn_sel,
  input logic         logic_mode,
  input logic         mask_hi,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_out
);
  logic armed    = 1'b0;
  logic prev_rst = 1'b0;

  always_ff @(posedge clk) begin
    armed    <= ~rst;
    prev_rst <= rst;
  end

  // R1
  always @(posedge clk) begin
    if (prev_rst) begin
      reset_clear_chk: assert (result == '0 && carry_out == 1'b0)
        else $error("reset_clear_chk");
    end
  end

  // R2
  logic_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(logic_mode) && $past(fn_sel) == SEL_PASS && !$past(carry_in))
    |-> (result == '0 && !carry_out));

  // R2
  logic_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(logic_mode) && $past(fn_sel) == SEL_DEC && !$past(carry_in))
    |-> (result == '1 && !carry_out));

  // R3
  logic_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(logic_mode) && $past(fn_sel) == SEL_DEC && $past(carry_in))
    |-> (result == '0 && carry_out));

  // R5
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(logic_mode) && $past(fn_sel) == SEL_ADD && !$past(mask_hi))
    |-> ({carry_out, result} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)}
                                 + {{W{1'b0}}, $past(carry_in)})));

  // R7
  mask_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(logic_mode) && $past(fn_sel) == SEL_PASS && $past(mask_hi)
     && !$past(carry_in))
    |-> (result == {{MASK_BITS{1'b0}}, $past(op_a[W-MASK_BITS-1:0])} && !carry_out));

  // R4
  minus_one_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(logic_mode) && $past(fn_sel) == SEL_MINUS1)
    |-> (result == ($past(carry_in) ? '0 : '1) && carry_out == $past(carry_in)));
endmodule

bind alu181_core alu181_core_chk #(.W(WIDTH), .MASK_BITS(MASK_BITS)) u_chk (.*);

// File: tb/alu181_core_tb.sv
module alu181_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_a = '0;
  logic [7:0] op_b = '0;
  logic [3:0] fn_sel = '0;
  logic       logic_mode = 1'b0;
  logic       mask_hi = 1'b0;
  logic       carry_in = 1'b0;
  logic [7:0] result;
  logic       carry_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu181_core u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .fn_sel(fn_sel),
    .logic_mode(logic_mode), .mask_hi(mask_hi), .carry_in(carry_in),
    .result(result), .carry_out(carry_out)
  );

  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic [3:0] s, input logic lm,
                                       input logic mk, input logic ci);
    logic [7:0] ae;
    logic [7:0] lv;
    logic [8:0] r;
    ae = (!lm && mk) ? (a & 8'h3F) : a;
    if (lm) begin
      case (s)
        4'd0:  lv = 8'h00;
        4'd1:  lv = a & b;
        4'd2:  lv = a & ~b;
        4'd3:  lv = a;
        4'd4:  lv = ~a & b;
        4'd5:  lv = b;
        4'd6:  lv = a ^ b;
        4'd7:  lv = a | b;
        4'd8:  lv = ~(a | b);
        4'd9:  lv = ~(a ^ b);
        4'd10: lv = ~b;
        4'd11: lv = a | ~b;
        4'd12: lv = ~a;
        4'd13: lv = ~a | b;
        4'd14: lv = ~(a & b);
        default: lv = 8'hFF;
      endcase
      r = {1'b0, lv} + {8'd0, ci};
    end else begin
      case (s)
        4'd0:  r = {1'b0, ae};
        4'd1:  r = {1'b0, ae} + {1'b0, ae & b};
        4'd2:  r = {1'b0, ae} + {1'b0, ae & ~b};
        4'd3:  r = {1'b0, ae} + {1'b0, ae};
        4'd4:  r = {1'b0, ae | b};
        4'd5:  r = {1'b0, ae} + {1'b0, b};
        4'd6:  r = {1'b0, ae | b} + {1'b0, ae & ~b};
        4'd7:  r = {1'b0, ae | b} + {1'b0, ae};
        4'd8:  r = {1'b0, ae | ~b};
        4'd9:  r = {1'b0, ae | ~b} + {1'b0, ae & b};
        4'd10: r = {1'b0, ae} + {1'b0, ~b};
        4'd11: r = {1'b0, ae | ~b} + {1'b0, ae};
        4'd12: r = 9'h0FF;
        4'd13: r = {1'b0, ae & b} + 9'h0FF;
        4'd14: r = {1'b0, ae & ~b} + 9'h0FF;
        default: r = {1'b0, ae} + 9'h0FF;
      endcase
      r = r + {8'd0, ci};
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [8:0] exp);
    checks++;
    if ({carry_out, result} !== exp) begin
      fails++;
      $display("FAIL %s: got cout=%0b res=%02h, expected cout=%0b res=%02h",
               tag, carry_out, result, exp[8], exp[7:0]);
    end
  endtask

  // Drive on a falling edge, sample on the next falling edge (one register stage)
  task automatic apply(input string tag, input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] s, input logic lm, input logic mk,
                       input logic ci, input logic [8:0] exp);
    @(negedge clk);
    op_a = a; op_b = b; fn_sel = s; logic_mode = lm; mask_hi = mk; carry_in = ci;
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    // R1: reset with busy inputs keeps outputs cleared
    op_a = 8'hFF; op_b = 8'h01; fn_sel = 4'd5; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", 9'h000);
    @(negedge clk);
    rst = 1'b0;

    // R1: one-cycle latency after reset release
    apply("R1 latency", 8'h12, 8'h34, 4'd5, 1'b0, 1'b0, 1'b0, 9'h046);

    // R9: carry across the slice boundary
    apply("R9 nibble carry", 8'h0F, 8'h01, 4'd5, 1'b0, 1'b0, 1'b0, 9'h010);
    apply("R9 full ripple", 8'hFF, 8'h00, 4'd5, 1'b0, 1'b0, 1'b1, 9'h100);
    apply("R9 low generate", 8'h88, 8'h08, 4'd5, 1'b0, 1'b0, 1'b0, 9'h090);

    // R5: binary sum with carry out
    apply("R5 add", 8'hC8, 8'h64, 4'd5, 1'b0, 1'b0, 1'b0, 9'h12C);
    apply("R5 add cin", 8'h7F, 8'h00, 4'd5, 1'b0, 1'b0, 1'b1, 9'h080);

    // R6: subtract
    apply("R6 sub ge", 8'h50, 8'h30, 4'd10, 1'b0, 1'b0, 1'b1, 9'h120);
    apply("R6 sub eq", 8'h5A, 8'h5A, 4'd10, 1'b0, 1'b0, 1'b1, 9'h100);
    apply("R6 sub lt", 8'h30, 8'h50, 4'd10, 1'b0, 1'b0, 1'b1, 9'h0E0);

    // R7: mask clears A[7:6] in arithmetic
    apply("R7 mask pass", 8'hFF, 8'h00, 4'd0, 1'b0, 1'b1, 1'b0, 9'h03F);
    apply("R7 mask add", 8'hC1, 8'h01, 4'd5, 1'b0, 1'b1, 1'b0, 9'h002);

    // R8: mask ignored in logic mode
    apply("R8 mask logic A", 8'hC3, 8'h5A, 4'd3, 1'b1, 1'b1, 1'b0, 9'h0C3);
    apply("R8 mask logic or", 8'hC0, 8'h0C, 4'd7, 1'b1, 1'b1, 1'b0, 9'h0CC);

    // R3: logic plus carry-in wraps from all ones
    apply("R3 ones inc", 8'h12, 8'h34, 4'd15, 1'b1, 1'b0, 1'b1, 9'h100);

    // R2 / R3 / R4 sweep over codes, modes, carry-in, mask and operand patterns
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        for (int code = 0; code < 16; code++) begin
          for (int fl = 0; fl < 8; fl++) begin
            logic [7:0] av;
            logic [7:0] bv;
            logic       lm;
            logic       mk;
            logic       ci;
            string      tg;
            av = 8'(ia * 16 + ((ia * 5 + 3) % 16));
            bv = 8'(ib * 16 + ((ib * 11 + 7) % 16));
            lm = fl[0];
            mk = fl[1];
            ci = fl[2];
            if (lm && !ci)      tg = "R2 logic";
            else if (lm)        tg = "R3 logic inc";
            else if (mk)        tg = "R4/R7 arith masked";
            else                tg = "R4 arith";
            apply(tg, av, bv, 4'(code), lm, mk, ci, model(av, bv, 4'(code), lm, mk, ci));
          end
        end
      end
    end

    // R1: reset reasserted mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", 9'h000);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule